// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block sits between a set of external interrupt lines (64 by default) and a processor core. Every line has an enable bit, a pending bit, an active bit and a priority level. Software programs these through a word-wide register bus. The controller looks at every line that is both enabled and pending and picks the most urgent one. It then filters that candidate through a base-priority threshold and decides whether the candidate may interrupt the handler already running. When it may, the controller raises a request to the core together with the line number.

The core answers with two strobes. An acknowledge accepts the presented line: it becomes the running handler, and the level it interrupted is saved on a small internal stack. An end-of-handler strobe retires the running handler and returns to the saved level. A programmable grouping value splits each priority into a preemption part and a subpriority part. Only the preemption part decides nesting. The full value still orders lines that are waiting together.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each line's enable bit is changed only through a set bank (word address 0x00 + n) and a clear bank (word address 0x08 + n), where n = line / 32 and the bit position is line % 32. A 1 bit sets or clears that line's enable bit. A 0 bit leaves it unchanged. Reading either address returns the enable bits of bank n.
- R2: Pending bits use a set bank at 0x10 + n and a clear bank at 0x18 + n, with the same bit mapping as R1. Reading either address returns the pending bits. Clearing a pending bit discards a request that has not yet been serviced.
- R3: Priority word w (address 0x40 + w) holds lines 4w to 4w+3. Line 4w+k uses byte lane k, bits [8k+7:8k]. Each lane is written only when its byte enable bus_be[k] is 1. Only the top three bits of each byte are stored, and the low five bits read back as 0.
- R4: irq_req is high only when some line is both enabled and pending. irq_vec then carries that line's number.
- R5: Among presentable lines, the one with the numerically smallest stored priority is chosen. A smaller value means more urgent. If stored priorities are equal, the lowest line number wins.
- R6: The base mask register at address 0x40 - 0x20 = 0x20 (bits [7:0], top three stored, low five read 0) blocks every line whose priority is greater than or equal to the mask. A mask of 0 blocks nothing.
- R7: The grouping register at 0x21 holds a value g in bits [2:0]. A write changes it only when bits [31:16] equal 0x05FA. A write with any other key leaves it unchanged.
- R8: The preemption group of a priority is its top min(g,3) stored bits. While a handler runs, a line is requested only if its group is numerically smaller than the running handler's group. So g = 0 allows no preemption, and g = 3 to 7 all behave like 3.
- R9: An acknowledge while irq_req is high clears the presented line's pending bit and marks it active. While a line is active, its level input does not set its pending bit.
- R10: An end-of-handler strobe retires the running handler, clears its active bit, and restores the interrupted level. Nested handlers unwind in reverse order. The stack cannot overflow.
- R11: If a retiring handler's interrupt input is still high at end-of-handler, its pending bit is set again.
- R12: A high interrupt input sets the pending bit of a line that is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Level-high interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Word address |
| bus_be | input | 4 | Byte enables, used by priority words and mask |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VW | Line number of the presented request |
| irq_ack | input | 1 | Core accepts the presented line |
| irq_eoh | input | 1 | Core ends the running handler |

## Verification
Read data is combinational, so a read is sampled in the same cycle in which the address is driven. Any register write, acknowledge or end-of-handler updates state on the one clock edge that ends its cycle. The request and vector follow that edge directly, and an interrupt input reaches the pending bit one edge after it rises. The bench drives every stimulus for exactly one cycle starting at a falling edge. It samples at the next falling edge plus a small delay, which is the first point at which each result is due. Nesting, grouping and masking are each checked at every step of an acknowledge and end-of-handler sequence.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NLINES = 64,
  parameter int PBITS  = 3,
  parameter int AW     = 8,
  parameter int VW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req,
  output logic [VW-1:0]     irq_vec,
  input  logic              irq_ack,
  input  logic              irq_eoh
);
  localparam int NBANK = (NLINES + 31) / 32;
  localparam int NPW   = (NLINES + 3) / 4;
  localparam int NEST  = 1 << PBITS;
  localparam int SPW   = $clog2(NEST + 1);
  localparam int SIW   = $clog2(NEST);
  localparam logic [AW-1:0] A_ENSET = AW'(8'h00);
  localparam logic [AW-1:0] A_ENCLR = AW'(8'h08);
  localparam logic [AW-1:0] A_PSET  = AW'(8'h10);
  localparam logic [AW-1:0] A_PCLR  = AW'(8'h18);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h20);
  localparam logic [AW-1:0] A_GRP   = AW'(8'h21);
  localparam logic [AW-1:0] A_PRIO  = AW'(8'h40);
  localparam logic [15:0]   KEY     = 16'h05FA;

  logic [NLINES-1:0] en_q, pend_q, act_q;
  logic [NLINES-1:0][PBITS-1:0] prio_q;
  logic [PBITS-1:0] mask_q;
  logic [2:0]       grp_q;

  logic             run_v;
  logic [PBITS-1:0] run_p;
  logic [VW-1:0]    run_l;
  logic [NEST-1:0]             stk_v;
  logic [NEST-1:0][PBITS-1:0]  stk_p;
  logic [NEST-1:0][VW-1:0]     stk_l;
  logic [SPW-1:0]   sp;

  wire [AW-1:0] base = {bus_addr[AW-1:3], 3'b000};
  wire [2:0]    bsel = bus_addr[2:0];
  wire [AW-1:0] pidx = bus_addr - A_PRIO;
  wire prio_hit = (bus_addr >= A_PRIO) && (bus_addr < A_PRIO + AW'(NPW));

  logic [NLINES-1:0] en_set_w, en_clr_w, p_set_w, p_clr_w;
  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      en_set_w[i] = bus_we && base == A_ENSET && bsel == 3'(i / 32) && bus_wdata[i % 32];
      en_clr_w[i] = bus_we && base == A_ENCLR && bsel == 3'(i / 32) && bus_wdata[i % 32];
      p_set_w[i]  = bus_we && base == A_PSET  && bsel == 3'(i / 32) && bus_wdata[i % 32];
      p_clr_w[i]  = bus_we && base == A_PCLR  && bsel == 3'(i / 32) && bus_wdata[i % 32];
    end
  end

  logic             best_v;
  logic [PBITS-1:0] best_p;
  logic [VW-1:0]    best_l;
  always_comb begin
    best_v = 1'b0;
    best_p = '1;
    best_l = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (en_q[i] && pend_q[i] && (mask_q == '0 || prio_q[i] < mask_q) &&
          (!best_v || prio_q[i] <= best_p)) begin
        best_v = 1'b1;
        best_p = prio_q[i];
        best_l = VW'(i);
      end
    end
  end

  logic [PBITS-1:0] gmask;
  always_comb begin
    logic [PBITS-1:0] ones;
    int k;
    ones  = '1;
    k     = (int'(grp_q) >= PBITS) ? PBITS : int'(grp_q);
    gmask = ~(ones >> k);
  end

  assign irq_req = best_v && (!run_v || ((best_p & gmask) < (run_p & gmask)));
  assign irq_vec = best_l;

  wire take   = irq_ack && irq_req;
  wire retire = irq_eoh && run_v && !take;

  logic [NLINES-1:0] pend_n, act_n;
  always_comb begin
    pend_n = pend_q | p_set_w | (irq_in & ~act_q);
    act_n  = act_q;
    if (retire) begin
      act_n[run_l] = 1'b0;
      if (irq_in[run_l]) pend_n[run_l] = 1'b1;
    end
    pend_n = pend_n & ~p_clr_w;
    if (take) begin
      pend_n[best_l] = 1'b0;
      act_n[best_l]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      prio_q <= '0;
      mask_q <= '0;
      grp_q  <= '0;
      run_v  <= 1'b0;
      run_p  <= '0;
      run_l  <= '0;
      stk_v  <= '0;
      stk_p  <= '0;
      stk_l  <= '0;
      sp     <= '0;
    end else begin
      en_q   <= (en_q | en_set_w) & ~en_clr_w;
      pend_q <= pend_n;
      act_q  <= act_n;
      if (bus_we && bus_addr == A_MASK && bus_be[0]) mask_q <= bus_wdata[7 -: PBITS];
      if (bus_we && bus_addr == A_GRP && bus_wdata[31:16] == KEY) grp_q <= bus_wdata[2:0];
      for (int i = 0; i < NLINES; i++)
        if (bus_we && prio_hit && int'(pidx) == i / 4 && bus_be[i % 4])
          prio_q[i] <= bus_wdata[8 * (i % 4) + 7 -: PBITS];
      if (take) begin
        stk_v[SIW'(sp)] <= run_v;
        stk_p[SIW'(sp)] <= run_p;
        stk_l[SIW'(sp)] <= run_l;
        sp    <= sp + 1'b1;
        run_v <= 1'b1;
        run_p <= best_p;
        run_l <= best_l;
      end else if (retire) begin
        run_v <= stk_v[SIW'(sp - 1'b1)];
        run_p <= stk_p[SIW'(sp - 1'b1)];
        run_l <= stk_l[SIW'(sp - 1'b1)];
        sp    <= sp - 1'b1;
      end
    end
  end

  logic [NBANK*32-1:0] en_pad, pend_pad;
  logic [NPW*4-1:0][PBITS-1:0] prio_pad;
  assign en_pad   = (NBANK*32)'(en_q);
  assign pend_pad = (NBANK*32)'(pend_q);
  assign prio_pad = (NPW*4*PBITS)'(prio_q);

  always_comb begin
    bus_rdata = '0;
    if ((base == A_ENSET || base == A_ENCLR) && int'(bsel) < NBANK)
      bus_rdata = en_pad[int'(bsel) * 32 +: 32];
    else if ((base == A_PSET || base == A_PCLR) && int'(bsel) < NBANK)
      bus_rdata = pend_pad[int'(bsel) * 32 +: 32];
    else if (bus_addr == A_MASK)
      bus_rdata[7:0] = {mask_q, (8-PBITS)'(0)};
    else if (bus_addr == A_GRP)
      bus_rdata[2:0] = grp_q;
    else if (prio_hit)
      for (int l = 0; l < 4; l++)
        bus_rdata[8*l +: 8] = {prio_pad[int'(pidx) * 4 + l], (8-PBITS)'(0)};
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
  parameter int NLINES = 64,
  parameter int PBITS  = 3,
  parameter int VW     = 6,
  parameter int NEST   = 8,
  parameter int SPW    = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         irq_req,
  input logic [VW-1:0]                irq_vec,
  input logic                         irq_ack,
  input logic                         irq_eoh,
  input logic [NLINES-1:0]            en_q,
  input logic [NLINES-1:0]            pend_q,
  input logic [NLINES-1:0]            act_q,
  input logic [NLINES-1:0][PBITS-1:0] prio_q,
  input logic [PBITS-1:0]             mask_q,
  input logic [SPW-1:0]               sp
);
  a_r4_req_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_q[irq_vec] && pend_q[irq_vec]);
  a_r6_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && mask_q != '0 |-> prio_q[irq_vec] < mask_q);
  a_r8_active_not_requested: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !act_q[irq_vec]);
  a_r9_ack_takes_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req |=> !pend_q[$past(irq_vec)] && act_q[$past(irq_vec)]);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(NEST));
  a_r10_eoh_pops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eoh && !irq_ack && sp != '0 |=> sp == $past(sp) - 1'b1);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NLINES(NLINES), .PBITS(PBITS), .VW(VW), .NEST(NEST), .SPW(SPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_eoh(irq_eoh), .en_q(en_q), .pend_q(pend_q),
  .act_q(act_q), .prio_q(prio_q), .mask_q(mask_q), .sp(sp)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [5:0]  irq_vec;
  logic        irq_ack = 1'b0;
  logic        irq_eoh = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_eoh(irq_eoh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrb(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrb(a, d, 4'hF);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic req_chk(input string req, input logic r, input logic [5:0] v);
    #1;
    chk({req, " request"}, 32'(irq_req), 32'(r));
    if (r) chk({req, " vector"}, 32'(irq_vec), 32'(v));
  endtask

  task automatic setp(input int line, input logic [7:0] v);
    wrb(8'(8'h40 + line / 4), 32'(v) << (8 * (line % 4)), 4'(1 << (line % 4)));
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic eoh();
    @(negedge clk); irq_eoh = 1'b1;
    @(negedge clk); irq_eoh = 1'b0;
  endtask

  task automatic t_reset();
    req_chk("reset", 1'b0, '0);
    rd_chk("reset enable", 8'h00, 0);
    rd_chk("reset pending", 8'h11, 0);
    rd_chk("reset group", 8'h21, 0);
    rd_chk("reset mask", 8'h20, 0);
    rd_chk("reset priority", 8'h40, 0);
  endtask

  task automatic t_enable();
    wr(8'h01, 32'h5);
    rd_chk("R1 set bank", 8'h01, 32'h5);
    rd_chk("R1 clear bank read", 8'h09, 32'h5);
    wr(8'h09, 32'h1);
    rd_chk("R1 clear one bit", 8'h01, 32'h4);
    wr(8'h09, 32'h0);
    wr(8'h01, 32'h0);
    rd_chk("R1 zero bits no effect", 8'h01, 32'h4);
    rd_chk("R1 other bank untouched", 8'h00, 32'h0);
    wr(8'h09, 32'h4);
  endtask

  task automatic t_pend();
    wr(8'h10, 32'h8);
    rd_chk("R2 set pending", 8'h10, 32'h8);
    req_chk("R4 pending but disabled", 1'b0, '0);
    wr(8'h00, 32'h8);
    req_chk("R4 enabled and pending", 1'b1, 6'd3);
    wr(8'h18, 32'h8);
    rd_chk("R2 clear pending", 8'h18, 32'h0);
    req_chk("R2 discarded", 1'b0, '0);
    wr(8'h08, 32'h8);
  endtask

  task automatic t_prio();
    wrb(8'h41, 32'hFFFF_FFFF, 4'b0010);
    rd_chk("R3 single lane", 8'h41, 32'h0000_E000);
    wr(8'h41, 32'h1F5F_BF3F);
    rd_chk("R3 top bits only", 8'h41, 32'h0040_A020);
    rd_chk("R3 neighbour word", 8'h40, 32'h0);
    wr(8'h41, 32'h0);
  endtask

  task automatic t_select();
    setp(10, 8'h40); setp(20, 8'h40); setp(40, 8'h20); setp(50, 8'h20);
    wr(8'h00, 32'h0010_0400); wr(8'h01, 32'h0004_0100);
    wr(8'h10, 32'h0010_0400); wr(8'h11, 32'h0004_0100);
    req_chk("R5 most urgent low line", 1'b1, 6'd40);
    wr(8'h19, 32'h100);
    req_chk("R5 next urgent", 1'b1, 6'd50);
    wr(8'h19, 32'h40000);
    req_chk("R5 tie lowest line", 1'b1, 6'd10);
    wr(8'h18, 32'h400);
    req_chk("R5 last", 1'b1, 6'd20);
    wr(8'h18, 32'h0010_0000);
    wr(8'h08, 32'h0010_0400); wr(8'h09, 32'h0004_0100);
    setp(10, 0); setp(20, 0); setp(40, 0); setp(50, 0);
  endtask

  task automatic t_mask();
    setp(7, 8'h60);
    wr(8'h00, 32'h80); wr(8'h10, 32'h80);
    wr(8'h20, 32'h60);
    req_chk("R6 equal masked", 1'b0, '0);
    wr(8'h20, 32'h80);
    req_chk("R6 below mask passes", 1'b1, 6'd7);
    wr(8'h20, 32'h9F);
    rd_chk("R6 mask readback", 8'h20, 32'h80);
    wr(8'h20, 32'h20);
    req_chk("R6 greater masked", 1'b0, '0);
    wr(8'h20, 32'h0);
    req_chk("R6 zero disables", 1'b1, 6'd7);
    wr(8'h18, 32'h80); wr(8'h08, 32'h80);
    setp(7, 0);
  endtask

  task automatic t_group();
    wr(8'h21, 32'h1234_0002);
    rd_chk("R7 bad key ignored", 8'h21, 32'h0);
    wr(8'h21, 32'h05FA_0002);
    rd_chk("R7 good key", 8'h21, 32'h2);
    wr(8'h21, 32'h05FA_0003);
    rd_chk("R7 rewrite", 8'h21, 32'h3);
  endtask

  task automatic t_nest();
    setp(8, 8'h80); setp(9, 8'h40); setp(12, 8'hA0); setp(13, 8'h80);
    wr(8'h00, 32'h3300);
    wr(8'h10, 32'h100);
    req_chk("R4 first line", 1'b1, 6'd8);
    ack();
    rd_chk("R9 ack clears pending", 8'h10, 32'h0);
    req_chk("R9 idle after ack", 1'b0, '0);
    wr(8'h10, 32'h3000);
    req_chk("R8 not more urgent waits", 1'b0, '0);
    wr(8'h10, 32'h200);
    req_chk("R8 preempt", 1'b1, 6'd9);
    ack();
    req_chk("R8 nested blocks", 1'b0, '0);
    rd_chk("R9 pending left", 8'h10, 32'h3000);
    eoh();
    req_chk("R10 back to outer level", 1'b0, '0);
    eoh();
    req_chk("R10 idle again", 1'b1, 6'd13);
    ack(); eoh();
    req_chk("R10 last waiting", 1'b1, 6'd12);
    ack(); eoh();
    req_chk("R10 all done", 1'b0, '0);
  endtask

  task automatic t_grouping();
    wr(8'h21, 32'h05FA_0001);
    setp(11, 8'h00);
    wr(8'h00, 32'h800);
    wr(8'h10, 32'h200);
    req_chk("R8 grouping 1 first", 1'b1, 6'd9);
    ack();
    wr(8'h10, 32'h800);
    req_chk("R8 same group no preempt", 1'b0, '0);
    wr(8'h21, 32'h05FA_0007);
    req_chk("R8 grouping 7 as 3", 1'b1, 6'd11);
    ack(); eoh(); eoh();
    wr(8'h21, 32'h05FA_0000);
    wr(8'h10, 32'h100);
    ack();
    wr(8'h10, 32'h800);
    req_chk("R8 grouping 0 no preempt", 1'b0, '0);
    eoh();
    req_chk("R8 grouping 0 after end", 1'b1, 6'd11);
    ack(); eoh();
    req_chk("R8 grouping done", 1'b0, '0);
    wr(8'h08, 32'h3B00);
    setp(8, 0); setp(9, 0); setp(11, 0); setp(12, 0); setp(13, 0);
  endtask

  task automatic t_level();
    wr(8'h01, 32'h2);
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk);
    rd_chk("R12 level pends", 8'h11, 32'h2);
    req_chk("R12 level request", 1'b1, 6'd33);
    ack();
    rd_chk("R9 active blocks level", 8'h11, 32'h0);
    @(negedge clk);
    rd_chk("R9 still blocked", 8'h11, 32'h0);
    eoh();
    rd_chk("R11 re-pend at end", 8'h11, 32'h2);
    ack();
    irq_in[33] = 1'b0;
    eoh();
    rd_chk("R11 no re-pend when low", 8'h11, 32'h0);
    req_chk("R11 idle", 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pend();
    t_prio();
    t_select();
    t_mask();
    t_group();
    t_nest();
    t_grouping();
    t_level();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule